// File: doc/BRIEF.md
# Resonant-Pole Commutation Gate Sequencer

This block drives the four gate enables of one soft-switched half-bridge leg. The leg has an upper and a lower main switch, snubber capacitors across them, and a pair of auxiliary switches that tie a resonant inductor to the DC midpoint. Each cycle the block reads signed fixed-point samples of load current, auxiliary-inductor current and pole voltage. When it receives a rail command it walks the leg from one rail to the other, so that every main and auxiliary switch changes state at zero voltage or zero current.

From the direction of travel and the sign and size of the load current, it picks one of two paths. The first is an assisted path, in which the auxiliary inductor is ramped to push the pole across. It serves both the case where the freewheeling diode is conducting and the case where the outgoing switch carries a small current. The second is a bypass path, in which the load current alone swings the pole. Currents use 4 fractional bits, so 60 A is 960 and 30 A is 480; these are the recommended defaults for the threshold and the boost. A transitional state that lasts too long puts the leg into a sticky fault. The block has no stream interface. The command is a single-cycle strobe with no ready signal and is never back-pressured. A command that arrives mid-sequence is parked in a one-deep slot, and a later command overwrites it. The samples are plain levels read on every clock.

Top module: `rpole_gate_seq`

## Requirements
- R1: After reset the leg sits in the low-latched state: state_code 0, only gate_lo asserted, busy 0, fault 0.
- R2: In the idle states only one main gate is on: state_code 0 asserts gate_lo alone, and state_code 1 asserts gate_hi alone. busy is 0 in both.
- R3: A command for the upper rail (cmd_rail=1) from state 0 enters the ramp state (code 2) when -i_load is not above cfg_thresh. In the ramp state gate_aux_up is asserted and gate_lo stays asserted.
- R4: The ramp state moves to the swing state (code 3) only in a cycle where i_aux > i_load + cfg_boost. In the swing state both main gates are off and the auxiliary gate stays on.
- R5: The swing state moves to the return state (code 4) once v_pole >= cfg_vhi. The incoming main gate (gate_hi) then turns on while the auxiliary gate stays on.
- R6: The return state ends when i_aux <= 0. The auxiliary gate drops and the leg is in state 1.
- R7: When -i_load > cfg_thresh, an upper-rail command turns gate_lo off at once and enters the free-swing state (code 5) with no gate on. The leg goes to state 1 once v_pole >= cfg_vhi.
- R8: A lower-rail command (cmd_rail=0) from state 1 mirrors R3 to R7 with the signs reversed. It uses gate_aux_dn. It bypasses when i_load > cfg_thresh, releases the upper switch when i_aux < i_load - cfg_boost, reaches the rail when v_pole <= cfg_vlo, and ends the return state when i_aux >= 0.
- R9: gate_hi and gate_lo are never on together. Neither is on in the cycle right after its partner was on.
- R10: A transitional state (codes 2 to 5) held for cfg_timeout cycles without meeting its exit condition enters the fault state (code 6). In that state fault=1, both auxiliary gates are off, and the main gates keep the values they had in the timed-out state. The fault persists until reset, and commands are ignored.
- R11: A command for the rail the leg already occupies has no effect. A command taken while busy is held, with the newest one winning, and is acted on the cycle after the leg reaches an idle state.
- R12: busy is 1 exactly in codes 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Single-cycle rail command strobe |
| cmd_rail | input | 1 | Target rail: 1 upper, 0 lower |
| i_load | input | CUR_W | Signed load current, positive out of the pole |
| i_aux | input | CUR_W | Signed auxiliary inductor current, positive into the pole |
| v_pole | input | V_W | Signed pole voltage relative to midpoint |
| cfg_thresh | input | CUR_W | Bypass current threshold |
| cfg_boost | input | CUR_W | Extra auxiliary current before release |
| cfg_vhi | input | V_W | Pole level counted as upper rail reached |
| cfg_vlo | input | V_W | Pole level counted as lower rail reached |
| cfg_timeout | input | TMO_W | Cycle limit for any transitional state |
| gate_hi | output | 1 | Upper main switch gate |
| gate_lo | output | 1 | Lower main switch gate |
| gate_aux_up | output | 1 | Auxiliary switch for upward transitions |
| gate_aux_dn | output | 1 | Auxiliary switch for downward transitions |
| state_code | output | 3 | Current state code |
| busy | output | 1 | Commutation in progress |
| fault | output | 1 | Sticky timeout fault |

## Verification
The upward assisted path is run twice. The first run uses a positive load current, where the diode conducts and the auxiliary current must climb past the load current. The second uses a negative load current at exactly the threshold, where release comes at a much smaller auxiliary current; this shows that the release limit follows i_load and that a current equal to the threshold does not bypass. One above the threshold, in each direction, the free-swing path is selected, which shows the sign of the bypass test per direction. Every inequality is probed one count either side of its limit. Random load, auxiliary and pole samples mixed with random command strobes are then compared cycle by cycle against a bench model, and this catches differences in timeout counting and command parking.

// File: rtl/rpole_pkg.sv
`timescale 1ns/1ps
package rpole_pkg;

  typedef enum logic [2:0] {
    ST_LAT_LO = 3'd0,
    ST_LAT_HI = 3'd1,
    ST_RAMP   = 3'd2,
    ST_SWING  = 3'd3,
    ST_RETURN = 3'd4,
    ST_FREE   = 3'd5,
    ST_FAULT  = 3'd6
  } leg_state_t;

  localparam int CUR_FRAC     = 4;
  localparam int DEF_THRESH_A = 60;
  localparam int DEF_BOOST_A  = 30;
  localparam int DEF_THRESH   = DEF_THRESH_A << CUR_FRAC;
  localparam int DEF_BOOST    = DEF_BOOST_A << CUR_FRAC;

  function automatic logic is_transit(leg_state_t s);
    return (s == ST_RAMP) || (s == ST_SWING) || (s == ST_RETURN) || (s == ST_FREE);
  endfunction

endpackage

// File: rtl/rpole_leg_cond.sv
`timescale 1ns/1ps
// Direction-aware comparisons of the plant samples against the settings.
module rpole_leg_cond #(
  parameter int CUR_W = 16,
  parameter int V_W   = 16
) (
  input  logic                    up,
  input  logic signed [CUR_W-1:0] i_load,
  input  logic signed [CUR_W-1:0] i_aux,
  input  logic signed [V_W-1:0]   v_pole,
  input  logic signed [V_W-1:0]   v_hi,
  input  logic signed [V_W-1:0]   v_lo,
  input  logic [CUR_W-1:0]        thresh,
  input  logic [CUR_W-1:0]        boost,
  output logic                    bypass,
  output logic                    released,
  output logic                    at_rail,
  output logic                    aux_done
);
  localparam int XW = CUR_W + 2;

  logic signed [XW-1:0] ld_x, ax_x, th_x, bs_x, rel_lim;

  always_comb begin
    ld_x     = {{2{i_load[CUR_W-1]}}, i_load};
    ax_x     = {{2{i_aux[CUR_W-1]}}, i_aux};
    th_x     = {2'b00, thresh};
    bs_x     = {2'b00, boost};
    rel_lim  = up ? (ld_x + bs_x) : (ld_x - bs_x);
    // outgoing switch carries -i_load going up, +i_load going down
    bypass   = up ? (ld_x < -th_x) : (ld_x > th_x);
    released = up ? (ax_x > rel_lim) : (ax_x < rel_lim);
    at_rail  = up ? (v_pole >= v_hi) : (v_pole <= v_lo);
    aux_done = up ? (ax_x <= 0) : (ax_x >= 0);
  end

endmodule

// File: rtl/rpole_dwell_timer.sv
`timescale 1ns/1ps
// Counts cycles spent in one transitional state; flags the last allowed one.
module rpole_dwell_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign expired = run && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (!cnt_inc[TMO_W])   cnt <= cnt_inc[TMO_W-1:0];
  end

  // R10: counter is cleared whenever the dwell is not running
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt == '0);

endmodule

// File: rtl/rpole_cmd_hold.sv
`timescale 1ns/1ps
// One-deep parking slot for rail commands that arrive mid-sequence.
module rpole_cmd_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_rail,
  input  logic idle,
  output logic req_valid,
  output logic req_rail
);
  logic pend_v, pend_rail;

  assign req_valid = cmd_valid | pend_v;
  assign req_rail  = cmd_valid ? cmd_rail : pend_rail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_rail <= 1'b0;
    end else if (idle) begin
      pend_v    <= 1'b0;
    end else if (cmd_valid) begin
      pend_v    <= 1'b1;
      pend_rail <= cmd_rail;
    end
  end

  // R11: a parked command survives until the leg is idle
  p_park_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && pend_v |=> pend_v);

endmodule

// File: rtl/rpole_gate_map.sv
`timescale 1ns/1ps
// Decodes state and direction into the four gate enables.
module rpole_gate_map
  import rpole_pkg::*;
(
  input  leg_state_t state,
  input  logic       up,
  input  logic       hold_hi,
  input  logic       hold_lo,
  output logic       gate_hi,
  output logic       gate_lo,
  output logic       aux_up,
  output logic       aux_dn,
  output logic       busy
);
  always_comb begin
    gate_hi = 1'b0;
    gate_lo = 1'b0;
    aux_up  = 1'b0;
    aux_dn  = 1'b0;
    busy    = is_transit(state);
    unique case (state)
      ST_LAT_LO: gate_lo = 1'b1;
      ST_LAT_HI: gate_hi = 1'b1;
      ST_RAMP: begin
        gate_lo = up;
        gate_hi = !up;
        aux_up  = up;
        aux_dn  = !up;
      end
      ST_SWING: begin
        aux_up  = up;
        aux_dn  = !up;
      end
      ST_RETURN: begin
        gate_hi = up;
        gate_lo = !up;
        aux_up  = up;
        aux_dn  = !up;
      end
      ST_FREE: ;
      default: begin
        gate_hi = hold_hi;
        gate_lo = hold_lo;
      end
    endcase
  end

endmodule

// File: rtl/rpole_gate_seq.sv
`timescale 1ns/1ps
module rpole_gate_seq
  import rpole_pkg::*;
#(
  parameter int CUR_W = 16,
  parameter int V_W   = 16,
  parameter int TMO_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_rail,
  input  logic signed [CUR_W-1:0] i_load,
  input  logic signed [CUR_W-1:0] i_aux,
  input  logic signed [V_W-1:0]   v_pole,
  input  logic [CUR_W-1:0]        cfg_thresh,
  input  logic [CUR_W-1:0]        cfg_boost,
  input  logic signed [V_W-1:0]   cfg_vhi,
  input  logic signed [V_W-1:0]   cfg_vlo,
  input  logic [TMO_W-1:0]        cfg_timeout,
  output logic                    gate_hi,
  output logic                    gate_lo,
  output logic                    gate_aux_up,
  output logic                    gate_aux_dn,
  output logic [2:0]              state_code,
  output logic                    busy,
  output logic                    fault
);
  leg_state_t state, state_n;
  logic up_q, up_eval, idle, transit;
  logic hold_hi, hold_lo;
  logic req_valid, req_rail;
  logic bypass, released, at_rail, aux_done, expired;

  assign idle    = (state == ST_LAT_LO) || (state == ST_LAT_HI);
  assign transit = is_transit(state);
  assign up_eval = transit ? up_q : (state == ST_LAT_LO);

  rpole_cmd_hold u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rail(cmd_rail),
    .idle(idle), .req_valid(req_valid), .req_rail(req_rail)
  );

  rpole_leg_cond #(.CUR_W(CUR_W), .V_W(V_W)) u_cond (
    .up(up_eval), .i_load(i_load), .i_aux(i_aux), .v_pole(v_pole),
    .v_hi(cfg_vhi), .v_lo(cfg_vlo), .thresh(cfg_thresh), .boost(cfg_boost),
    .bypass(bypass), .released(released), .at_rail(at_rail), .aux_done(aux_done)
  );

  rpole_dwell_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(transit), .restart(state_n != state),
    .limit(cfg_timeout), .expired(expired)
  );

  rpole_gate_map u_map (
    .state(state), .up(up_q), .hold_hi(hold_hi), .hold_lo(hold_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .aux_up(gate_aux_up),
    .aux_dn(gate_aux_dn), .busy(busy)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_LAT_LO: if (req_valid && req_rail)  state_n = bypass ? ST_FREE : ST_RAMP;
      ST_LAT_HI: if (req_valid && !req_rail) state_n = bypass ? ST_FREE : ST_RAMP;
      ST_RAMP: begin
        if (released)     state_n = ST_SWING;
        else if (expired) state_n = ST_FAULT;
      end
      ST_SWING: begin
        if (at_rail)      state_n = ST_RETURN;
        else if (expired) state_n = ST_FAULT;
      end
      ST_RETURN: begin
        if (aux_done)     state_n = up_q ? ST_LAT_HI : ST_LAT_LO;
        else if (expired) state_n = ST_FAULT;
      end
      ST_FREE: begin
        if (at_rail)      state_n = up_q ? ST_LAT_HI : ST_LAT_LO;
        else if (expired) state_n = ST_FAULT;
      end
      default:            state_n = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_LAT_LO;
      up_q    <= 1'b1;
      hold_hi <= 1'b0;
      hold_lo <= 1'b0;
    end else begin
      state <= state_n;
      if (idle) up_q <= (state == ST_LAT_LO);
      if (state_n == ST_FAULT && state != ST_FAULT) begin
        hold_hi <= gate_hi;
        hold_lo <= gate_lo;
      end
    end
  end

  assign state_code = state;
  assign fault      = (state == ST_FAULT);

  // R9: main switches are never on together
  p_mains_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R9: no main gate directly after its partner
  p_hi_after_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> !$past(gate_lo));
  p_lo_after_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo |-> !$past(gate_hi));
  // R8: only one auxiliary switch at a time
  p_aux_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_aux_up && gate_aux_dn));
  // R4: outgoing main released only after aux current exceeded the limit
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWING) && ($past(state) == ST_RAMP) |-> $past(released));
  // R5: incoming upper gate only after pole reached the upper rail
  p_zv_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) && !fault |-> $past(v_pole >= cfg_vhi));
  // R8: incoming lower gate only after pole reached the lower rail
  p_zv_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) && !fault |-> $past(v_pole <= cfg_vlo));
  // R6: upward aux switch opens only at zero current
  p_zc_aux_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_aux_up) && !fault |-> $past(i_aux) <= 0);
  // R10: fault is sticky and quiet on the auxiliary side
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !gate_aux_up && !gate_aux_dn);

endmodule

// File: tb/rpole_gate_seq_test.sv
`timescale 1ns/1ps
module rpole_gate_seq_test;
  localparam int THR = 960, BST = 480, VHI = 1000, VLO = -1000, TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rail = 1'b0;
  logic signed [15:0] i_load = '0, i_aux = '0, v_pole = '0;
  logic signed [15:0] cfg_vhi = 16'(VHI), cfg_vlo = 16'(VLO);
  logic [15:0] cfg_thresh = 16'(THR), cfg_boost = 16'(BST), cfg_timeout = 16'(TMO);
  logic gate_hi, gate_lo, gate_aux_up, gate_aux_dn, busy, fault;
  logic [2:0] state_code;

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_cnt = 0;
  bit m_up = 1, m_pv = 0, m_pr = 0, m_fh = 0, m_fl = 0;
  bit prev_hi = 0, prev_lo = 1;

  always #10 clk = ~clk;

  rpole_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rail(cmd_rail),
    .i_load(i_load), .i_aux(i_aux), .v_pole(v_pole), .cfg_thresh(cfg_thresh),
    .cfg_boost(cfg_boost), .cfg_vhi(cfg_vhi), .cfg_vlo(cfg_vlo),
    .cfg_timeout(cfg_timeout), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .gate_aux_up(gate_aux_up), .gate_aux_dn(gate_aux_dn),
    .state_code(state_code), .busy(busy), .fault(fault)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {hi, lo, aux_up, aux_dn} from the requirements
  function automatic logic [3:0] exp_gates(int st, bit up, bit fh, bit fl);
    case (st)
      0: return 4'b0100;
      1: return 4'b1000;
      2: return up ? 4'b0110 : 4'b1001;
      3: return up ? 4'b0010 : 4'b0001;
      4: return up ? 4'b1010 : 4'b0101;
      5: return 4'b0000;
      default: return {fh, fl, 2'b00};
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step();
    int il = int'(i_load), ia = int'(i_aux), vp = int'(v_pole), tmo = int'(cfg_timeout);
    bit idle = (m_st <= 1);
    bit transit = (m_st >= 2 && m_st <= 5);
    bit rv = cmd_valid || m_pv;
    bit rr = cmd_valid ? cmd_rail : m_pr;
    bit up = transit ? m_up : (m_st == 0);
    bit byp = up ? (il < -THR) : (il > THR);
    bit rel = up ? (ia > il + BST) : (ia < il - BST);
    bit rail = up ? (vp >= VHI) : (vp <= VLO);
    bit done = up ? (ia <= 0) : (ia >= 0);
    bit ex = transit && (m_cnt + 1 >= tmo);
    int nx = m_st;
    logic [3:0] g;
    case (m_st)
      0: if (rv && rr) nx = byp ? 5 : 2;
      1: if (rv && !rr) nx = byp ? 5 : 2;
      2: if (rel) nx = 3; else if (ex) nx = 6;
      3: if (rail) nx = 4; else if (ex) nx = 6;
      4: if (done) nx = up ? 1 : 0; else if (ex) nx = 6;
      5: if (rail) nx = up ? 1 : 0; else if (ex) nx = 6;
      default: nx = 6;
    endcase
    if (nx == 6 && m_st != 6) begin
      g = exp_gates(m_st, m_up, m_fh, m_fl);
      m_fh = g[3];
      m_fl = g[2];
    end
    m_cnt = (transit && nx == m_st) ? m_cnt + 1 : 0;
    if (idle) m_pv = 0;
    else if (cmd_valid) begin m_pv = 1; m_pr = cmd_rail; end
    if (idle) m_up = (m_st == 0);
    m_st = nx;
  endtask

  task automatic compare();
    logic [3:0] g = exp_gates(m_st, m_up, m_fh, m_fl);
    logic [3:0] a = {gate_hi, gate_lo, gate_aux_up, gate_aux_dn};
    bit eb = (m_st >= 2 && m_st <= 5);
    check(a == g, tag_of(m_st), int'(a), int'(g));
    check(int'(state_code) == m_st, tag_of(m_st), int'(state_code), m_st);
    check(busy == eb, "R12", int'(busy), int'(eb));
    check(fault == (m_st == 6), "R10", int'(fault), int'(m_st == 6));
    // R9: interlock seen at the ports
    check(!(gate_hi && gate_lo) && !(gate_hi && prev_lo) && !(gate_lo && prev_hi),
          "R9", int'({gate_hi, gate_lo}), int'({prev_hi, prev_lo}));
    prev_hi = gate_hi;
    prev_lo = gate_lo;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cmd(bit rail);
    cmd_valid = 1'b1;
    cmd_rail  = rail;
    cyc();
    cmd_valid = 1'b0;
  endtask

  task automatic expect_code(int code, string tag);
    check(int'(state_code) == code, tag, int'(state_code), code);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    m_st = 0; m_cnt = 0; m_up = 1; m_pv = 0; m_pr = 0; m_fh = 0; m_fl = 0;
    prev_hi = 0; prev_lo = 1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: reset state
    check({gate_hi, gate_lo, gate_aux_up, gate_aux_dn} == 4'b0100, "R1",
          int'({gate_hi, gate_lo, gate_aux_up, gate_aux_dn}), 4);
    check(state_code == 3'd0 && !busy && !fault, "R1", int'(state_code), 0);

    // R11: command for the occupied rail does nothing
    i_load = 16'sd200; i_aux = 16'sd0; v_pole = -16'sd1000;
    cmd(1'b0); expect_code(0, "R11");
    cyc(); expect_code(0, "R11");

    // diode path upward
    cmd(1'b1); expect_code(2, "R3");
    check(gate_lo && gate_aux_up && busy, "R3", int'({gate_lo, gate_aux_up}), 3);
    i_aux = 16'sd680; cyc(); expect_code(2, "R4");
    i_aux = 16'sd681; cyc(); expect_code(3, "R4");
    check(!gate_hi && !gate_lo && gate_aux_up, "R4", int'({gate_hi, gate_lo}), 0);
    v_pole = 16'sd999; cyc(); expect_code(3, "R5");
    v_pole = 16'sd1000; cyc(); expect_code(4, "R5");
    check(gate_hi && gate_aux_up, "R5", int'({gate_hi, gate_aux_up}), 3);
    i_aux = 16'sd1; cyc(); expect_code(4, "R6");
    i_aux = 16'sd0; cyc(); expect_code(1, "R6");
    check(!gate_aux_up && !busy, "R6", int'(gate_aux_up), 0);

    // downward assisted path with a parked command
    i_load = 16'sd100;
    cmd(1'b0); expect_code(2, "R8");
    check(gate_hi && gate_aux_dn, "R8", int'({gate_hi, gate_aux_dn}), 3);
    cmd(1'b1); expect_code(2, "R11");
    i_aux = -16'sd380; cyc(); expect_code(2, "R8");
    i_aux = -16'sd381; cyc(); expect_code(3, "R8");
    v_pole = -16'sd999; cyc(); expect_code(3, "R8");
    v_pole = -16'sd1000; cyc(); expect_code(4, "R8");
    i_aux = -16'sd1; cyc(); expect_code(4, "R8");
    i_aux = 16'sd0; cyc(); expect_code(0, "R8");
    cyc(); expect_code(2, "R11");
    i_aux = 16'sd600; cyc(); expect_code(3, "R11");
    v_pole = 16'sd1000; cyc(); expect_code(4, "R11");
    i_aux = 16'sd0; cyc(); expect_code(1, "R11");

    // downward bypass
    i_load = 16'sd961;
    cmd(1'b0); expect_code(5, "R8");
    v_pole = -16'sd999; cyc(); expect_code(5, "R8");
    v_pole = -16'sd1000; cyc(); expect_code(0, "R8");

    // upward low-current switch path, load exactly at threshold
    i_load = -16'sd960; i_aux = 16'sd0;
    cmd(1'b1); expect_code(2, "R3");
    i_aux = -16'sd480; cyc(); expect_code(2, "R4");
    i_aux = -16'sd479; cyc(); expect_code(3, "R4");
    v_pole = 16'sd1000; cyc(); expect_code(4, "R5");
    cyc(); expect_code(1, "R6");

    // back down, then upward bypass
    i_load = 16'sd961; cmd(1'b0); v_pole = -16'sd1000; cyc(); expect_code(0, "R8");
    i_load = -16'sd961;
    cmd(1'b1); expect_code(5, "R7");
    check({gate_hi, gate_lo, gate_aux_up, gate_aux_dn} == 4'b0000, "R7",
          int'({gate_hi, gate_lo, gate_aux_up, gate_aux_dn}), 0);
    v_pole = 16'sd1000; cyc(); expect_code(1, "R7");
    check(gate_hi, "R7", int'(gate_hi), 1);

    // random phase against the bench model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      int r;
      cmd_valid = ($urandom_range(3) == 0);
      cmd_rail  = $urandom_range(1) == 1;
      i_load = 16'(int'($urandom_range(2400)) - 1200);
      i_aux  = 16'(int'($urandom_range(3000)) - 1500);
      r = int'($urandom_range(2));
      if (r == 0)      v_pole = 16'(VHI + int'($urandom_range(50)));
      else if (r == 1) v_pole = 16'(VLO - int'($urandom_range(50)));
      else             v_pole = 16'(int'($urandom_range(1800)) - 900);
      cyc();
      if (m_st == 6) do_reset();
    end

    // directed timeout
    cfg_timeout = 16'd5;
    do_reset();
    i_load = 16'sd0; i_aux = 16'sd0; v_pole = -16'sd1000;
    cmd(1'b1); expect_code(2, "R10");
    for (int k = 0; k < 4; k++) begin cyc(); expect_code(2, "R10"); end
    cyc(); expect_code(6, "R10");
    check(fault && gate_lo && !gate_hi && !gate_aux_up, "R10",
          int'({fault, gate_lo, gate_hi, gate_aux_up}), 12);
    cmd(1'b0); expect_code(6, "R10");
    i_aux = 16'sd2000; cmd(1'b1); expect_code(6, "R10");
    check(fault && gate_lo, "R10", int'({fault, gate_lo}), 3);
    cfg_timeout = 16'(TMO);
    do_reset();
    cyc(); expect_code(0, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule